// File: doc/BRIEF.md
# Two-Wire Counter Readout Target

This block is the serial target side of an event counter. It sits on a two-wire bus (SCL clock, SDA open-drain data) at a fixed 7-bit address. A bus controller can read a 24-bit count value and read or write a 24-bit scratch register. The count value comes from a counter outside this block through `count_in`. The block takes a private copy of it whenever a start condition is recognized, so a readout is never torn by the counter moving mid-transfer.

A write transfer always begins with a command byte. Bit 7 of that byte is a pointer bit. When it is 1, the next three bytes fill the scratch register. When it is 0, a later read inside the same transfer, reached through a repeated start, returns the scratch register instead of the count. A stop clears the pointer, so a read that follows a stop always returns the count. The three least significant scratch bits form a command field. Writing the code 010 there fires a one-cycle counter-clear strobe; the written bits are stored in every case.

SCL and SDA are oversampled on the system clock through two-flop synchronizers and a run-length glitch filter. The block holds no data stream: every pin is a plain level or a single-cycle strobe, so there is no valid/ready pairing and no back-pressure at the edge. The bus itself paces all transfers.

Top module: `twowire_counter_target`

## Requirements
- R1: An address byte whose upper seven bits equal 0110010 is acknowledged: SDA is pulled low during the ninth clock. Bit 0 selects read (1) or write (0). Any other address is not acknowledged, and the block ignores the bus until the next start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. `bus_busy` rises after a recognized start and falls after a recognized stop.
- R3: In a write transfer, bit 7 of the first byte after the address is the pointer bit. Its bits 6 down to 0 have no effect.
- R4: After a command byte with pointer 1, the next three bytes are stored into `scratch_q[23:16]`, `[15:8]` and `[7:0]` in that order. Every written byte is acknowledged.
- R5: If bits [2:0] of the third data byte equal 010, `clr_strobe` is high for exactly one system clock. Any other value gives no strobe. The byte is stored either way.
- R6: A read transfer that follows a stop returns the count bytes, most significant first. The count is the value of `count_in` when the start was recognized.
- R7: A command byte with pointer 0, followed by a repeated start and a read address, returns the three scratch bytes, most significant first.
- R8: Read bytes past the third return 8'hFF. A not-acknowledge from the controller ends the read, and SDA is released.
- R9: A stop clears the pointer, so a read after a pointer-0 command and a stop returns the count.
- R10: A stop is not recognized while the block pulls SDA low. Nine clocks with SDA released, followed by a stop, return the block to idle.
- R11: After reset, `sda_pull`, `bus_busy` and `clr_strobe` are 0 and `scratch_q` is 0.
- R12: Data bytes that follow a pointer-0 command are acknowledged and discarded. They do not change `scratch_q` and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad (wired bus value) |
| count_in | input | 24 | Live count value, copied at each start |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| bus_busy | output | 1 | High from a recognized start until a recognized stop |
| clr_strobe | output | 1 | One-cycle counter-clear command |
| scratch_q | output | 24 | Scratch register contents, command field in [2:0] |

## Verification
The bench builds the block with its defaults: address 0110010, a three-sample glitch filter and three register bytes. It drives the bus with a quarter-bit of eight system clocks. This leaves room for the full synchronizer and filter latency before each controller sample. At this size a single transfer reaches the fourth read byte and so the all-ones fill. The command-field decode is reached with both the clear code and a non-clear code. The stuck-bus case, where a stop is attempted while the block holds SDA low, is reached with a zero count, so that the block is pulling low through the attempted stop.

// File: rtl/twc_pkg.sv
package twc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WRITE = 3'd2,
    ST_READ  = 3'd3,
    ST_HOLD  = 3'd4
  } twc_state_t;

  localparam int BYTE_W = 8;
  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_CLR = 3'b010;
endpackage

// File: rtl/twc_line_filter.sv
module twc_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      filt <= 1'b1;
      run  <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == filt) begin
        run <= '0;
      end else if (run == CW'(FILT_LEN - 1)) begin
        filt <= s2;
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/twc_bus_cond.sv
module twc_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/twc_engine.sv
module twc_engine
  import twc_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'b0110010,
  parameter int REG_BYTES = 3,
  localparam int REG_W = REG_BYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_c,
  input  logic             stop_c,
  input  logic [REG_W-1:0] count_in,
  output logic             sda_pull,
  output logic             bus_busy,
  output logic             clr_strobe,
  output logic [REG_W-1:0] scratch_q
);
  localparam int IW = $clog2(REG_BYTES + 2);
  localparam logic [IW-1:0] IDX_MAX = IW'(REG_BYTES + 1);

  twc_state_t state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [IW-1:0]     idx;
  logic              rd_mode, ptr_scr, wr_ok, mnack;
  logic [REG_W-1:0]  snap;
  logic              start_ok, stop_ok;
  logic [7:0]        rd_cur, rd_nxt;

  function automatic logic [7:0] rd_sel(input logic [IW-1:0] k,
                                        input logic [REG_W-1:0] src);
    logic [7:0] v;
    v = 8'hFF;
    for (int i = 0; i < REG_BYTES; i++)
      if (k == IW'(i)) v = src[REG_W-1-BYTE_W*i -: BYTE_W];
    return v;
  endfunction

  // a condition on the bus is invisible while this side holds SDA low
  assign start_ok = start_c & ~sda_pull;
  assign stop_ok  = stop_c & ~sda_pull;
  assign rd_cur   = rd_sel(idx, ptr_scr ? scratch_q : snap);
  assign rd_nxt   = rd_sel((idx == IDX_MAX) ? idx : idx + 1'b1,
                           ptr_scr ? scratch_q : snap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      idx        <= '0;
      rd_mode    <= 1'b0;
      ptr_scr    <= 1'b0;
      wr_ok      <= 1'b0;
      mnack      <= 1'b0;
      snap       <= '0;
      sda_pull   <= 1'b0;
      bus_busy   <= 1'b0;
      clr_strobe <= 1'b0;
      scratch_q  <= '0;
    end else begin
      clr_strobe <= 1'b0;
      if (start_ok) begin
        state    <= ST_ADDR;
        bitcnt   <= '0;
        idx      <= '0;
        wr_ok    <= 1'b0;
        snap     <= count_in;
        bus_busy <= 1'b1;
      end else if (stop_ok) begin
        state    <= ST_IDLE;
        bitcnt   <= '0;
        ptr_scr  <= 1'b0;
        bus_busy <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WRITE: begin
            if (scl_rise) begin
              if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (shreg[7:1] == TGT_ADDR) begin
                  sda_pull <= 1'b1;
                  rd_mode  <= shreg[0];
                end else begin
                  state <= ST_HOLD;
                end
              end else begin
                sda_pull <= 1'b1;
                if (idx == '0) begin
                  ptr_scr <= ~shreg[7];
                  wr_ok   <= shreg[7];
                end else if (wr_ok) begin
                  for (int i = 0; i < REG_BYTES; i++)
                    if (idx == IW'(i + 1))
                      scratch_q[REG_W-1-BYTE_W*i -: BYTE_W] <= shreg;
                  if (idx == IW'(REG_BYTES) && shreg[CMD_W-1:0] == CMD_CLR)
                    clr_strobe <= 1'b1;
                end
              end
            end else if (scl_fall && bitcnt == 4'd9) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (rd_mode) begin
                  state    <= ST_READ;
                  sda_pull <= ~rd_cur[7];
                end else begin
                  state    <= ST_WRITE;
                  sda_pull <= 1'b0;
                end
              end else begin
                sda_pull <= 1'b0;
                if (idx != IDX_MAX) idx <= idx + 1'b1;
              end
            end
          end
          ST_READ: begin
            if (scl_rise) begin
              if (bitcnt == 4'd8) mnack <= sda_lvl;
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt != 4'd0 && bitcnt < 4'd8) begin
                sda_pull <= ~rd_cur[3'd7 - bitcnt[2:0]];
              end else if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0;
              end else if (bitcnt == 4'd9) begin
                bitcnt <= '0;
                if (mnack) begin
                  state <= ST_HOLD;
                end else begin
                  if (idx != IDX_MAX) idx <= idx + 1'b1;
                  sda_pull <= ~rd_nxt[7];
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: the SDA drive only ever moves while SCL is low
  p_pull_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_pull) |-> !scl_lvl);

  // R1, R4: an acknowledge is raised only once a full byte has been clocked in
  p_ack_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && state != ST_READ) |-> bitcnt == 4'd8);

  // R2: once a start is taken the bus is marked busy
  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> bus_busy);

  // R8, R10: in idle or parked states SDA is never pulled
  p_quiet_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_HOLD) |-> !sda_pull);

  // R5: the clear command is a single-cycle pulse
  p_clr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_strobe |=> !clr_strobe);

  // R1: bit counter stays inside one nine-clock frame
  p_bitcnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);
endmodule

// File: rtl/twowire_counter_target.sv
module twowire_counter_target #(
  parameter logic [6:0] TGT_ADDR = 7'b0110010,
  parameter int FILT_LEN = 3,
  parameter int REG_BYTES = 3,
  localparam int REG_W = REG_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [REG_W-1:0] count_in,
  output logic             sda_pull,
  output logic             bus_busy,
  output logic             clr_strobe,
  output logic [REG_W-1:0] scratch_q
);
  logic [1:0] raw_v, filt_v;
  logic scl_rise, scl_fall, start_c, stop_c;

  assign raw_v = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    twc_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_v[g]),
      .filt (filt_v[g])
    );
  end

  twc_bus_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (filt_v[0]),
    .sda_f   (filt_v[1]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c)
  );

  twc_engine #(.TGT_ADDR(TGT_ADDR), .REG_BYTES(REG_BYTES)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (filt_v[0]),
    .sda_lvl   (filt_v[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .count_in  (count_in),
    .sda_pull  (sda_pull),
    .bus_busy  (bus_busy),
    .clr_strobe(clr_strobe),
    .scratch_q (scratch_q)
  );
endmodule

// File: tb/twowire_counter_target_tb_top.sv
module twowire_counter_target_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [23:0] count_in = '0;
  logic sda_pull, bus_busy, clr_strobe;
  logic [23:0] scratch_q;
  logic sda_bus;
  int total = 0;
  int bad = 0;
  int clr_cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  always @(posedge clk) if (clr_strobe) clr_cycles++;

  twowire_counter_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .count_in(count_in), .sda_pull(sda_pull), .bus_busy(bus_busy),
    .clr_strobe(clr_strobe), .scratch_q(scratch_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(2 * Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    logic x;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      get_bit(x);
      d = {d[6:0], x};
    end
    put_bit(~give_ack);
  endtask

  task automatic t_reset();
    chk("R11 sda_pull", {31'd0, sda_pull}, 32'd0);
    chk("R11 bus_busy", {31'd0, bus_busy}, 32'd0);
    chk("R11 clr_strobe", {31'd0, clr_strobe}, 32'd0);
    chk("R11 scratch", {8'd0, scratch_q}, 32'd0);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    chk("R2 busy after start", {31'd0, bus_busy}, 32'd1);
    wr_byte(8'hA0, a);
    chk("R1 foreign address not acked", {31'd0, a}, 32'd0);
    wr_byte(8'h81, a);
    chk("R1 ignored until next start", {31'd0, a}, 32'd0);
    bus_stop();
    chk("R2 idle after stop", {31'd0, bus_busy}, 32'd0);
    chk("R1 scratch untouched", {8'd0, scratch_q}, 32'd0);
  endtask

  task automatic t_write_keep();
    logic a;
    int c0;
    c0 = clr_cycles;
    bus_start();
    wr_byte(8'h64, a); chk("R1 write address acked", {31'd0, a}, 32'd1);
    wr_byte(8'h81, a); chk("R4 command acked", {31'd0, a}, 32'd1);
    wr_byte(8'hAB, a); chk("R4 byte1 acked", {31'd0, a}, 32'd1);
    wr_byte(8'hCD, a); chk("R4 byte2 acked", {31'd0, a}, 32'd1);
    wr_byte(8'hEF, a); chk("R4 byte3 acked", {31'd0, a}, 32'd1);
    bus_stop();
    chk("R4 scratch stored", {8'd0, scratch_q}, 32'h00ABCDEF);
    chk("R5 no strobe for code 111", clr_cycles - c0, 32'd0);
  endtask

  task automatic t_write_clr();
    logic a;
    int c0;
    c0 = clr_cycles;
    bus_start();
    wr_byte(8'h64, a);
    wr_byte(8'hFF, a); chk("R3 low command bits ignored", {31'd0, a}, 32'd1);
    wr_byte(8'h12, a);
    wr_byte(8'h34, a);
    wr_byte(8'h52, a);
    bus_stop();
    chk("R5 data stored with clear code", {8'd0, scratch_q}, 32'h00123452);
    chk("R5 one-cycle strobe", clr_cycles - c0, 32'd1);
  endtask

  task automatic t_read_count();
    logic a;
    logic [7:0] d;
    count_in = 24'hA5C30F;
    bus_start();
    wr_byte(8'h65, a); chk("R1 read address acked", {31'd0, a}, 32'd1);
    count_in = 24'h111111;
    rd_byte(1'b1, d); chk("R6 count byte hi", {24'd0, d}, 32'hA5);
    rd_byte(1'b1, d); chk("R6 count byte mid", {24'd0, d}, 32'hC3);
    rd_byte(1'b1, d); chk("R6 count byte lo", {24'd0, d}, 32'h0F);
    rd_byte(1'b0, d); chk("R8 fill byte", {24'd0, d}, 32'hFF);
    chk("R8 released after nack", {31'd0, sda_pull}, 32'd0);
    bus_stop();
    chk("R2 idle after read", {31'd0, bus_busy}, 32'd0);
  endtask

  task automatic t_read_scratch();
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte(8'h64, a);
    wr_byte(8'h01, a); chk("R7 pointer-0 command acked", {31'd0, a}, 32'd1);
    bus_start();
    chk("R2 busy across repeated start", {31'd0, bus_busy}, 32'd1);
    wr_byte(8'h65, a);
    rd_byte(1'b1, d); chk("R7 scratch hi", {24'd0, d}, 32'h12);
    rd_byte(1'b1, d); chk("R7 scratch mid", {24'd0, d}, 32'h34);
    rd_byte(1'b0, d); chk("R7 scratch lo", {24'd0, d}, 32'h52);
    bus_stop();
  endtask

  task automatic t_ptr_cleared();
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte(8'h64, a);
    wr_byte(8'h01, a);
    bus_stop();
    bus_start();
    wr_byte(8'h65, a);
    rd_byte(1'b1, d); chk("R9 count after stop hi", {24'd0, d}, 32'h11);
    rd_byte(1'b1, d); chk("R9 count after stop mid", {24'd0, d}, 32'h11);
    rd_byte(1'b0, d); chk("R9 count after stop lo", {24'd0, d}, 32'h11);
    bus_stop();
  endtask

  task automatic t_ptr0_discard();
    logic a;
    int c0;
    c0 = clr_cycles;
    bus_start();
    wr_byte(8'h64, a);
    wr_byte(8'h00, a);
    wr_byte(8'h77, a); chk("R12 discarded byte acked", {31'd0, a}, 32'd1);
    wr_byte(8'h88, a);
    wr_byte(8'h8A, a);
    bus_stop();
    chk("R12 scratch unchanged", {8'd0, scratch_q}, 32'h00123452);
    chk("R12 no strobe", clr_cycles - c0, 32'd0);
  endtask

  task automatic t_stuck();
    logic a, x;
    count_in = 24'h000000;
    bus_start();
    wr_byte(8'h65, a);
    get_bit(x); chk("R6 zero bit driven", {31'd0, x}, 32'd0);
    get_bit(x);
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2 * Q);
    chk("R10 stop ignored, still busy", {31'd0, bus_busy}, 32'd1);
    chk("R10 SDA still held low", {31'd0, sda_bus}, 32'd0);
    m_scl = 1'b0; tick(Q);
    for (int i = 0; i < 9; i++) get_bit(x);
    chk("R10 SDA released after clocks", {31'd0, sda_pull}, 32'd0);
    bus_stop();
    chk("R10 idle after recovery stop", {31'd0, bus_busy}, 32'd0);
  endtask

  initial begin
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(5);
    t_bad_addr();
    t_write_keep();
    t_write_clr();
    t_read_count();
    t_read_scratch();
    t_ptr_cleared();
    t_ptr0_discard();
    t_stuck();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule